// File: doc/BRIEF.md
# SCSI DMA channel control engine

This block is the control and status half of a bus-master DMA channel that sits beside a SCSI protocol core. Software programs a start count, a start address and a start descriptor address. It then issues a command whose two low bits pick one of four operations. A START loads the working copies of those registers and enables DMA toward the core. As the core moves data, it presents transfer requests. Each request carries a byte length and a direction. The engine clips the length to what remains, and it then counts the working count down and the working address up.

Status flags record a SCSI interrupt, a completed transfer, an abort, an error, a power-down condition and a flush completion. The core's interrupt line and the done flag merge into one level interrupt. Bit 24 of a separate control register selects how the error, abort and done flags are cleared. When the bit is 0, reading the status register clears them. When the bit is 1, software clears them by writing ones. The memory bus cycles themselves and any walk of a descriptor list are handled elsewhere.

The transfer-request port is valid/ready. `xfer_ready` is low in any cycle that carries a register write, because a register write has priority. A request is taken in every cycle where `xfer_valid` and `xfer_ready` are both high. The request does not need to be held; `xfer_grant` reports the clipped length in the same cycle.

Top module: `dmac_engine`

## Requirements
- R1: After reset, registers read as follows: command 0, working count 0, working address 0xFFFFFFFF, status 0, working descriptor address 0xFFFFFFFD. `irq`, `core_dma_en` and `core_cancel` are low.
- R2: The register indices are command 0, start count 1, start address 2, working count 3, working address 4, status 5, start descriptor address 6, working descriptor address 7 and control 8. Indices 1, 2, 6 and 8 read back what was written. Writes to indices 3, 4 and 7 have no effect. Reads of indices above 8 return 0.
- R3: Writing the command with bits [1:0]=3 (START) has several effects. It copies the start count to the working count, the start address to the working address and the start descriptor address to the working descriptor address. It clears status bits 0 to 5 and drives `core_dma_en` high.
- R4: Command bits [1:0]=0 (IDLE) drive `core_dma_en` low. Bits [1:0]=2 (ABORT) make `core_cancel` high for exactly the one cycle after the write. Bits [1:0]=1 (BLAST) set status bit 5 (0x20) and change no other status bit.
- R5: When a transfer request's direction differs from command bit 7 (1 means device to memory), the request is ignored: `xfer_grant` is 0 and the working count and working address do not change.
- R6: An accepted request with a matching direction grants min(length, working count). The working count drops by the grant and the working address rises by the grant on the next clock edge.
- R7: A rising edge on `core_irq` sets status bit 4 (0x10). A falling edge clears it.
- R8: A rising edge on `core_irq` also sets status bit 3 (done, 0x08) in the same cycle, but only when the command field is START and the working count is 0.
- R9: `irq` = status bit 4 OR (command bit 6 AND status bit 3).
- R10: With control bit 24 = 0, a status read returns the current value. The read then clears status bits 1, 2 and 3 (0x0E). Writes to status have no effect.
- R11: With control bit 24 = 1, a status write clears those of bits 1, 2 and 3 that are written as 1. Other bits are unaffected. Status reads do not clear anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (drives clear-on-read) |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| xfer_valid | input | 1 | Transfer request valid |
| xfer_ready | output | 1 | Transfer request ready (low during register writes) |
| xfer_dir | input | 1 | Request direction, 1 = device to memory |
| xfer_len | input | 16 | Requested length in bytes |
| xfer_grant | output | 16 | Granted length for the current request |
| core_irq | input | 1 | Interrupt level from the SCSI core |
| core_dma_en | output | 1 | DMA enable toward the core |
| core_cancel | output | 1 | One-cycle cancel pulse toward the core |
| irq | output | 1 | Merged level interrupt |

## Verification
The assertions assume that the register port and the transfer port never compete for the working registers. The bench honours this: it raises `xfer_valid` only in cycles without a register write, and it checks that `xfer_ready` is high. The assertions also assume that `core_irq` changes only between clock edges and that START is never written in the same cycle as a `core_irq` edge. The bench moves `core_irq` in cycles of its own, away from any command write. Transfer lengths and start counts are swept over small ranges so that clipped, exact and partial grants all occur.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dmac_op_e;

  localparam int IDX_CMD   = 0;
  localparam int IDX_SCNT  = 1;
  localparam int IDX_SADR  = 2;
  localparam int IDX_WCNT  = 3;
  localparam int IDX_WADR  = 4;
  localparam int IDX_STAT  = 5;
  localparam int IDX_SDSC  = 6;
  localparam int IDX_WDSC  = 7;
  localparam int IDX_CTRL  = 8;

  localparam int ST_W      = 6;
  localparam int BIT_SCSI  = 4;
  localparam int BIT_DONE  = 3;
  localparam int BIT_FLUSH = 5;
  localparam logic [ST_W-1:0] ST_CLRABLE = 6'h0E;

  localparam int CMD_DIR_BIT  = 7;
  localparam int CMD_DIE_BIT  = 6;
endpackage

// File: rtl/dmac_xfer_track.sv
module dmac_xfer_track #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic [CNT_W-1:0] load_addr,
  input  logic             req_fire,
  input  logic             dir_ok,
  input  logic [LEN_W-1:0] req_len,
  output logic [LEN_W-1:0] grant,
  output logic [CNT_W-1:0] wcnt,
  output logic [CNT_W-1:0] waddr
);
  logic [CNT_W-1:0] len_ext;
  logic [LEN_W-1:0] clipped;

  assign len_ext = CNT_W'(req_len);
  always_comb begin
    if (len_ext > wcnt) clipped = wcnt[LEN_W-1:0];
    else                clipped = req_len;
  end
  assign grant = (req_fire && dir_ok) ? clipped : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt  <= '0;
      waddr <= '1;
    end else if (load) begin
      wcnt  <= load_cnt;
      waddr <= load_addr;
    end else if (req_fire && dir_ok) begin
      wcnt  <= wcnt - CNT_W'(clipped);
      waddr <= waddr + CNT_W'(clipped);
    end
  end

  // R5
  ign_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !dir_ok && !load) |=> ($stable(wcnt) && $stable(waddr)));

  // R6
  move_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && dir_ok && !load) |=> ((waddr - $past(waddr)) == ($past(wcnt) - wcnt)));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && dir_ok && !load) |=> (wcnt <= $past(wcnt)));
endmodule

// File: rtl/dmac_status_irq.sv
module dmac_status_irq
  import dmac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_clr,
  input  logic            blast_set,
  input  logic            core_irq,
  input  logic            op_is_start,
  input  logic            wcnt_zero,
  input  logic            rd_clr,
  input  logic            w1c_en,
  input  logic [ST_W-1:0] w1c_val,
  input  logic            done_ie,
  output logic [ST_W-1:0] stat,
  output logic            irq
);
  logic            core_q;
  logic            rise, fall;
  logic [ST_W-1:0] clr_m, set_m;

  assign rise = core_irq && !core_q;
  assign fall = !core_irq && core_q;

  always_comb begin
    clr_m = '0;
    if (start_clr) clr_m = '1;
    if (rd_clr)    clr_m = clr_m | ST_CLRABLE;
    if (w1c_en)    clr_m = clr_m | (w1c_val & ST_CLRABLE);
    if (fall)      clr_m[BIT_SCSI] = 1'b1;
    set_m = '0;
    if (blast_set) set_m[BIT_FLUSH] = 1'b1;
    if (rise) begin
      set_m[BIT_SCSI] = 1'b1;
      if (op_is_start && wcnt_zero) set_m[BIT_DONE] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat   <= '0;
      core_q <= 1'b0;
    end else begin
      stat   <= (stat & ~clr_m) | set_m;
      core_q <= core_irq;
    end
  end

  assign irq = stat[BIT_SCSI] | (done_ie & stat[BIT_DONE]);

  // R7
  scsi_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_irq && !core_q) |=> stat[BIT_SCSI]);

  // R8
  done_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_irq && !core_q && op_is_start && wcnt_zero) |=> stat[BIT_DONE]);

  // R11
  w1c_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_en && !start_clr && !blast_set && core_irq == core_q) |=> ((stat & ~$past(stat)) == '0));
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
  import dmac_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int AW       = 4,
  parameter int LEN_W    = 16,
  parameter int CTRL_BIT = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_rd_en,
  input  logic [AW-1:0]    reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             xfer_valid,
  output logic             xfer_ready,
  input  logic             xfer_dir,
  input  logic [LEN_W-1:0] xfer_len,
  output logic [LEN_W-1:0] xfer_grant,
  input  logic             core_irq,
  output logic             core_dma_en,
  output logic             core_cancel,
  output logic             irq
);
  localparam logic [REG_W-1:0] WDSC_RST = ~REG_W'(2);

  logic [REG_W-1:0] cmd_q, scnt_q, sadr_q, sdsc_q, wdsc_q, ctrl_q;
  logic [REG_W-1:0] wcnt, waddr;
  logic [ST_W-1:0]  stat;
  dmac_op_e         wr_op, cur_op;
  logic             wr_cmd, start_wr, stat_hit, req_fire;

  assign wr_op    = dmac_op_e'(reg_wdata[1:0]);
  assign cur_op   = dmac_op_e'(cmd_q[1:0]);
  assign wr_cmd   = reg_wr_en && (reg_addr == AW'(IDX_CMD));
  assign start_wr = wr_cmd && (wr_op == OP_START);
  assign stat_hit = (reg_addr == AW'(IDX_STAT));
  assign xfer_ready = !reg_wr_en;
  assign req_fire   = xfer_valid && xfer_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      scnt_q      <= '0;
      sadr_q      <= '0;
      sdsc_q      <= '0;
      wdsc_q      <= WDSC_RST;
      ctrl_q      <= '0;
      core_dma_en <= 1'b0;
      core_cancel <= 1'b0;
    end else begin
      core_cancel <= wr_cmd && (wr_op == OP_ABORT);
      if (wr_cmd) begin
        cmd_q <= reg_wdata;
        if (wr_op == OP_IDLE)  core_dma_en <= 1'b0;
        if (wr_op == OP_START) begin
          core_dma_en <= 1'b1;
          wdsc_q      <= sdsc_q;
        end
      end
      if (reg_wr_en && reg_addr == AW'(IDX_SCNT)) scnt_q <= reg_wdata;
      if (reg_wr_en && reg_addr == AW'(IDX_SADR)) sadr_q <= reg_wdata;
      if (reg_wr_en && reg_addr == AW'(IDX_SDSC)) sdsc_q <= reg_wdata;
      if (reg_wr_en && reg_addr == AW'(IDX_CTRL)) ctrl_q <= reg_wdata;
    end
  end

  dmac_xfer_track #(.CNT_W(REG_W), .LEN_W(LEN_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_wr),
    .load_cnt  (scnt_q),
    .load_addr (sadr_q),
    .req_fire  (req_fire),
    .dir_ok    (xfer_dir == cmd_q[CMD_DIR_BIT]),
    .req_len   (xfer_len),
    .grant     (xfer_grant),
    .wcnt      (wcnt),
    .waddr     (waddr)
  );

  dmac_status_irq u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_clr   (start_wr),
    .blast_set   (wr_cmd && (wr_op == OP_BLAST)),
    .core_irq    (core_irq),
    .op_is_start (cur_op == OP_START),
    .wcnt_zero   (wcnt == '0),
    .rd_clr      (reg_rd_en && stat_hit && !ctrl_q[CTRL_BIT]),
    .w1c_en      (reg_wr_en && stat_hit && ctrl_q[CTRL_BIT]),
    .w1c_val     (reg_wdata[ST_W-1:0]),
    .done_ie     (cmd_q[CMD_DIE_BIT]),
    .stat        (stat),
    .irq         (irq)
  );

  always_comb begin
    case (reg_addr)
      AW'(IDX_CMD):  reg_rdata = cmd_q;
      AW'(IDX_SCNT): reg_rdata = scnt_q;
      AW'(IDX_SADR): reg_rdata = sadr_q;
      AW'(IDX_WCNT): reg_rdata = wcnt;
      AW'(IDX_WADR): reg_rdata = waddr;
      AW'(IDX_STAT): reg_rdata = REG_W'(stat);
      AW'(IDX_SDSC): reg_rdata = sdsc_q;
      AW'(IDX_WDSC): reg_rdata = wdsc_q;
      AW'(IDX_CTRL): reg_rdata = ctrl_q;
      default:       reg_rdata = '0;
    endcase
  end

  // R4
  cancel_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_cancel |-> ($past(reg_wr_en) && $past(reg_addr) == AW'(IDX_CMD) && $past(reg_wdata[1:0]) == 2'd2));

  // R3
  start_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (core_dma_en && stat == '0));

  // R2
  wdsc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_wr |=> $stable(wdsc_q));
endmodule

// File: tb/tb_dmac_engine.sv
`timescale 1ns/1ps
module tb_dmac_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_valid = 1'b0, xfer_dir = 1'b0;
  logic        xfer_ready;
  logic [15:0] xfer_len = '0;
  logic [15:0] xfer_grant;
  logic        core_irq = 1'b0;
  logic        core_dma_en, core_cancel, irq;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dmac_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_dir(xfer_dir),
    .xfer_len(xfer_len), .xfer_grant(xfer_grant), .core_irq(core_irq),
    .core_dma_en(core_dma_en), .core_cancel(core_cancel), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 4'(a); reg_wdata = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = 4'(a);
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic req(input int len, input logic dir, output logic [15:0] g);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_len = 16'(len); xfer_dir = dir;
    #1 g = xfer_grant;
    check("R6 ready", 32'(xfer_ready), 32'd1);
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  task automatic set_core(input logic v);
    @(negedge clk);
    core_irq = v;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 dma_en", 32'(core_dma_en), 0);
    check("R1 cancel", 32'(core_cancel), 0);
    rd(0, v); check("R1 cmd", v, 32'h0);
    rd(3, v); check("R1 wcnt", v, 32'h0);
    rd(4, v); check("R1 waddr", v, 32'hFFFF_FFFF);
    rd(5, v); check("R1 status", v, 32'h0);
    rd(7, v); check("R1 wdesc", v, 32'hFFFF_FFFD);

    // R2 register map
    wr(1, 32'h0000_0123); wr(2, 32'h8000_1000); wr(6, 32'h0000_4440); wr(8, 32'h00AB_0000);
    rd(1, v); check("R2 scnt", v, 32'h0000_0123);
    rd(2, v); check("R2 sadr", v, 32'h8000_1000);
    rd(6, v); check("R2 sdesc", v, 32'h0000_4440);
    rd(8, v); check("R2 ctrl", v, 32'h00AB_0000);
    wr(3, 32'h55); wr(4, 32'h66); wr(7, 32'h77);
    rd(3, v); check("R2 wcnt ro", v, 32'h0);
    rd(4, v); check("R2 waddr ro", v, 32'hFFFF_FFFF);
    rd(7, v); check("R2 wdesc ro", v, 32'hFFFF_FFFD);
    for (int a = 9; a < 16; a++) begin
      rd(a, v); check("R2 unmapped", v, 32'h0);
    end
    wr(8, 32'h0);

    // R3 START load and status clear
    set_core(1'b1);
    wr(0, 32'h1);
    rd(5, v); check("R4 blast flag", v, 32'h30);
    wr(0, 32'h3);
    check("R3 dma_en", 32'(core_dma_en), 1);
    rd(5, v); check("R3 status cleared", v, 32'h0);
    rd(3, v); check("R3 wcnt", v, 32'h0000_0123);
    rd(4, v); check("R3 waddr", v, 32'h8000_1000);
    rd(7, v); check("R3 wdesc", v, 32'h0000_4440);
    set_core(1'b0);

    // R4 IDLE, ABORT
    wr(0, 32'h0);
    check("R4 idle dma_en", 32'(core_dma_en), 0);
    wr(0, 32'h3);
    wr(0, 32'h2);
    check("R4 cancel high", 32'(core_cancel), 1);
    check("R4 abort keeps dma_en", 32'(core_dma_en), 1);
    @(negedge clk);
    check("R4 cancel one cycle", 32'(core_cancel), 0);

    // R6 sweep of count against length
    wr(2, 32'h0000_2000);
    for (int c = 0; c < 7; c++) begin
      for (int l = 0; l < 9; l++) begin
        int m, l2, m2;
        m = (l < c) ? l : c;
        wr(1, 32'(c)); wr(0, 32'h3);
        req(l, 1'b0, g);
        check("R6 grant", 32'(g), 32'(m));
        rd(3, v); check("R6 wcnt", v, 32'(c - m));
        rd(4, v); check("R6 waddr", v, 32'h2000 + 32'(m));
        l2 = 3;
        m2 = (l2 < c - m) ? l2 : c - m;
        req(l2, 1'b0, g);
        check("R6 second grant", 32'(g), 32'(m2));
        rd(3, v); check("R6 second wcnt", v, 32'(c - m - m2));
      end
    end

    // R5 direction mismatch
    wr(1, 32'd10); wr(0, 32'h83);
    req(4, 1'b0, g); check("R5 grant", 32'(g), 0);
    rd(3, v); check("R5 wcnt", v, 32'd10);
    rd(4, v); check("R5 waddr", v, 32'h2000);
    req(4, 1'b1, g); check("R5 match grant", 32'(g), 4);
    rd(3, v); check("R5 match wcnt", v, 32'd6);

    // R7 R8 R9 with clear-on-read (R10)
    wr(1, 32'd0); wr(0, 32'h43);
    set_core(1'b1);
    check("R9 irq scsi", 32'(irq), 1);
    rd(5, v); check("R8 done forced", v, 32'h18);
    rd(5, v); check("R10 read cleared done", v, 32'h10);
    set_core(1'b0);
    rd(5, v); check("R7 fall clears", v, 32'h0);
    check("R9 irq low", 32'(irq), 0);
    wr(1, 32'd5); wr(0, 32'h43);
    set_core(1'b1);
    rd(5, v); check("R8 no done nonzero", v, 32'h10);
    set_core(1'b0);
    wr(1, 32'd0); wr(0, 32'h43);
    set_core(1'b1); set_core(1'b0);
    check("R9 irq done only", 32'(irq), 1);
    wr(0, 32'h00);
    check("R9 irq done masked", 32'(irq), 0);
    wr(5, 32'hFF);
    rd(5, v); check("R10 write ignored", v, 32'h08);
    rd(5, v); check("R10 cleared", v, 32'h0);

    // R11 write-one-to-clear
    wr(8, 32'h0100_0000);
    wr(0, 32'h43);
    set_core(1'b1); set_core(1'b0);
    rd(5, v); check("R11 read keeps", v, 32'h08);
    rd(5, v); check("R11 read keeps again", v, 32'h08);
    wr(5, 32'h06);
    rd(5, v); check("R11 other bits", v, 32'h08);
    wr(5, 32'h08);
    rd(5, v); check("R11 cleared", v, 32'h0);
    set_core(1'b1);
    wr(5, 32'h3F);
    rd(5, v); check("R11 scsi kept", v, 32'h18 & 32'h10);
    set_core(1'b0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule